// File: doc/BRIEF.md
# Banked Nibble Register File for a Real-Time Clock

This block is the host-side register window of a small real-time clock. The host sees sixteen 4-bit locations. It addresses them with a 4-bit address, a 4-bit write bus and single-cycle read and write strobes. The low thirteen locations (0x0 to 0xC) are shared by four banks. A control nibble at 0xD selects the bank. The four banks are:

- the live time digits, held in an external counter core;
- alarm nibbles together with hour-format and leap-year settings;
- two independent scratch nibble memories.

Locations 0xD, 0xE and 0xF are the same in every bank: the control nibble, a write-only test nibble and a write-only command nibble.

Host writes to the time bank become load strobes toward the counter core. Host reads of the time bank return the core's digit vector. The control nibble also carries a counting-enable bit, and the host clears it to freeze the digits while it reads them. One-second ticks that arrive while counting is frozen are held back. At most one such tick is remembered, and it is released as a single increment once counting resumes.

Top module: `rtc_nibble_regfile`

## Requirements
- R1: Control nibble bits 1:0 select the bank seen at 0x0..0xC: 00 time digits, 01 alarm/config, 10 scratch A, 11 scratch B. The control nibble is at 0xD, is reachable from every bank and reads back all four bits.
- R2: Reads are registered. `host_rdata` takes the addressed nibble at the clock edge where `host_rd` is high and holds its value otherwise. After reset, the control nibble and `host_rdata` are zero.
- R3: In the time bank, a write to address a (0..0xC) gives a one-cycle `tcore_ld` on the next cycle, with `tcore_ld_idx`=a and `tcore_ld_val`=data. A read of address a returns `tcore_digits[4a+3:4a]`.
- R4: Each scratch bank stores 13 nibbles. Writes to one scratch bank never change the other.
- R5: In bank 01, addresses 0x2..0x8 are seven read/write alarm nibbles, exposed on `alarm_nibs` with address 0x2 in bits 3:0. Bit 0 at 0xA selects the hour format (1 = 24-hour). Bits 1:0 at 0xB hold the leap-year phase. The unused bits of 0xA and 0xB read as 0. Addresses 0x0, 0x1, 0x9 and 0xC read 0, and writes to them are ignored.
- R6: A write to 0xF acts as a command and always reads 0. Bit 0 clears every alarm nibble. Bit 1 raises `div_clr` for one cycle on the next cycle. Bits 2 and 3 are latched into `pulse16_en` and `pulse1_en`.
- R7: A write to 0xE latches the value on `test_bits`. Reads of 0xE return 0.
- R8: Control bit 3 (`timer_en`) gates `tick_1s`. A tick that is sampled while the bit is set gives `tcore_inc` on the next cycle. A tick that is sampled while the bit is clear gives no increment and sets one pending flag; later ticks do not add to it. When the bit is set again, one increment is issued.
- R9: Control bit 2 is output as `alarm_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Host nibble address |
| host_wdata | input | 4 | Host write nibble |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_rdata | output | 4 | Registered read nibble |
| tick_1s | input | 1 | One-second tick from the divider |
| tcore_digits | input | 52 | Counter core digits, nibble i in bits 4i+3:4i |
| tcore_ld | output | 1 | Digit load strobe to the counter core |
| tcore_ld_idx | output | 4 | Digit index to load |
| tcore_ld_val | output | 4 | Digit value to load |
| tcore_inc | output | 1 | One-second increment to the counter core |
| timer_en | output | 1 | Counting enable (control bit 3) |
| alarm_en | output | 1 | Alarm enable (control bit 2) |
| alarm_nibs | output | 28 | Alarm nibbles for the comparator |
| hour24 | output | 1 | 24-hour format select |
| leap_phase | output | 2 | Leap-year phase |
| div_clr | output | 1 | Sub-second divider clear pulse |
| pulse16_en | output | 1 | 16 Hz pulse output enable |
| pulse1_en | output | 1 | 1 Hz pulse output enable |
| test_bits | output | 4 | Latched test nibble |

## Verification
A behavioural model in the bench is compared with every registered output on every clock. The two scratch banks are filled with different patterns and read back crosswise, which separates a correct bank decode from one that aliases the two scratch banks or the alarm bank. Alarm and configuration writes are mixed with writes to the unused bank-01 addresses, and an alarm clear follows, which shows that clearing and ignoring act only where they should. Two different digit vectors are read through the time bank, and ticks are sent while counting is enabled, while it is frozen, and again after it is re-enabled. These show whether the increment gating and the single pending carry are right.

// File: rtl/rtc_rf_pkg.sv
package rtc_rf_pkg;

    localparam int NIB_W       = 4;
    localparam int WIN_DEPTH   = 13;
    localparam int ALARM_FIRST = 2;
    localparam int ALARM_LAST  = 8;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [1:0] {
        BANK_TIME = 2'b00,
        BANK_CFG  = 2'b01,
        BANK_SCRA = 2'b10,
        BANK_SCRB = 2'b11
    } bank_e;

    // control nibble layout: bit3 counting, bit2 alarm, bits1:0 bank
    typedef struct packed {
        logic  count_en;
        logic  alarm_en;
        bank_e bank;
    } ctrl_t;

    // command nibble layout
    typedef struct packed {
        logic pulse1;
        logic pulse16;
        logic div_clear;
        logic alarm_clear;
    } cmd_t;

    localparam nib_t ADR_CTRL = 4'hD;
    localparam nib_t ADR_TEST = 4'hE;
    localparam nib_t ADR_CMD  = 4'hF;
    localparam nib_t ADR_FMT  = 4'hA;
    localparam nib_t ADR_LEAP = 4'hB;

    function automatic logic in_window(input nib_t a, input int depth);
        return int'(a) < depth;
    endfunction

    function automatic logic in_range(input nib_t a, input int lo, input int hi);
        return (int'(a) >= lo) && (int'(a) <= hi);
    endfunction

endpackage

// File: rtl/rtc_rf_tick_gate.sv
module rtc_rf_tick_gate (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic tick,
    output logic inc
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            inc    <= 1'b0;
        end else begin
            inc <= enable && (tick || pend_q);
            if (enable) pend_q <= tick && pend_q;
            else        pend_q <= pend_q || tick;
        end
    end
endmodule

// File: rtl/rtc_rf_scratch.sv
module rtc_rf_scratch
    import rtc_rf_pkg::*;
#(
    parameter int DEPTH  = WIN_DEPTH,
    parameter int BLOCKS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [BLOCKS-1:0]       wr_en,
    input  nib_t                    addr,
    input  nib_t                    wdata,
    output logic [BLOCKS*NIB_W-1:0] rd_flat
);
    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        nib_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en[b] && in_window(addr, DEPTH)) begin
                mem[addr] <= wdata;
            end
        end

        assign rd_flat[b*NIB_W +: NIB_W] = in_window(addr, DEPTH) ? mem[addr] : '0;
    end
endmodule

// File: rtl/rtc_rf_alarm_cfg.sv
module rtc_rf_alarm_cfg
    import rtc_rf_pkg::*;
#(
    parameter int LO = ALARM_FIRST,
    parameter int HI = ALARM_LAST,
    localparam int CNT = HI - LO + 1,
    localparam int IW  = (CNT > 1) ? $clog2(CNT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 clear,
    input  nib_t                 addr,
    input  nib_t                 wdata,
    output logic [CNT*NIB_W-1:0] alarm_flat,
    output logic                 hour24,
    output logic [1:0]           leap,
    output nib_t                 rd_nib
);
    nib_t       al_q [CNT];
    nib_t       off;
    logic       hit;

    assign off = addr - nib_t'(LO);
    assign hit = in_range(addr, LO, HI);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < CNT; i++) al_q[i] <= '0;
        end else if (wr_en && hit) begin
            al_q[off[IW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hour24 <= 1'b0;
            leap   <= '0;
        end else if (wr_en) begin
            if (addr == ADR_FMT)  hour24 <= wdata[0];
            if (addr == ADR_LEAP) leap   <= wdata[1:0];
        end
    end

    for (genvar i = 0; i < CNT; i++) begin : g_out
        assign alarm_flat[i*NIB_W +: NIB_W] = al_q[i];
    end

    always_comb begin
        rd_nib = '0;
        if (hit)                   rd_nib = al_q[off[IW-1:0]];
        else if (addr == ADR_FMT)  rd_nib = {3'b000, hour24};
        else if (addr == ADR_LEAP) rd_nib = {2'b00, leap};
    end
endmodule

// File: rtl/rtc_nibble_regfile.sv
module rtc_nibble_regfile
    import rtc_rf_pkg::*;
#(
    parameter int DEPTH    = WIN_DEPTH,
    parameter int ALARM_LO = ALARM_FIRST,
    parameter int ALARM_HI = ALARM_LAST,
    localparam int ACNT    = ALARM_HI - ALARM_LO + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            host_addr,
    input  logic [3:0]            host_wdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    output logic [3:0]            host_rdata,
    input  logic                  tick_1s,
    input  logic [DEPTH*4-1:0]    tcore_digits,
    output logic                  tcore_ld,
    output logic [3:0]            tcore_ld_idx,
    output logic [3:0]            tcore_ld_val,
    output logic                  tcore_inc,
    output logic                  timer_en,
    output logic                  alarm_en,
    output logic [ACNT*4-1:0]     alarm_nibs,
    output logic                  hour24,
    output logic [1:0]            leap_phase,
    output logic                  div_clr,
    output logic                  pulse16_en,
    output logic                  pulse1_en,
    output logic [3:0]            test_bits
);
    ctrl_t ctrl_q;
    cmd_t  cmd;
    nib_t  digit [DEPTH];
    logic  wr_win, wr_time, wr_cfg, wr_cmd;
    logic [1:0] wr_scr;
    logic [2*NIB_W-1:0] scr_rd;
    nib_t  cfg_rd, rd_mux;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dig
        assign digit[i] = tcore_digits[i*NIB_W +: NIB_W];
    end

    assign cmd     = cmd_t'(host_wdata);
    assign wr_win  = host_wr && in_window(host_addr, DEPTH);
    assign wr_time = wr_win && (ctrl_q.bank == BANK_TIME);
    assign wr_cfg  = wr_win && (ctrl_q.bank == BANK_CFG);
    assign wr_scr  = {wr_win && (ctrl_q.bank == BANK_SCRB),
                      wr_win && (ctrl_q.bank == BANK_SCRA)};
    assign wr_cmd  = host_wr && (host_addr == ADR_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            test_bits  <= '0;
            pulse16_en <= 1'b0;
            pulse1_en  <= 1'b0;
            div_clr    <= 1'b0;
        end else begin
            div_clr <= wr_cmd && cmd.div_clear;
            if (host_wr && host_addr == ADR_CTRL) ctrl_q    <= ctrl_t'(host_wdata);
            if (host_wr && host_addr == ADR_TEST) test_bits <= host_wdata;
            if (wr_cmd) begin
                pulse16_en <= cmd.pulse16;
                pulse1_en  <= cmd.pulse1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcore_ld     <= 1'b0;
            tcore_ld_idx <= '0;
            tcore_ld_val <= '0;
        end else begin
            tcore_ld <= wr_time;
            if (wr_time) begin
                tcore_ld_idx <= host_addr;
                tcore_ld_val <= host_wdata;
            end
        end
    end

    rtc_rf_scratch #(.DEPTH(DEPTH), .BLOCKS(2)) u_scratch (
        .clk(clk), .rst(rst), .wr_en(wr_scr), .addr(host_addr),
        .wdata(host_wdata), .rd_flat(scr_rd)
    );

    rtc_rf_alarm_cfg #(.LO(ALARM_LO), .HI(ALARM_HI)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_cfg), .clear(wr_cmd && cmd.alarm_clear),
        .addr(host_addr), .wdata(host_wdata), .alarm_flat(alarm_nibs),
        .hour24(hour24), .leap(leap_phase), .rd_nib(cfg_rd)
    );

    rtc_rf_tick_gate u_gate (
        .clk(clk), .rst(rst), .enable(ctrl_q.count_en),
        .tick(tick_1s), .inc(tcore_inc)
    );

    always_comb begin
        rd_mux = '0;
        if (host_addr == ADR_CTRL) begin
            rd_mux = nib_t'(ctrl_q);
        end else if (in_window(host_addr, DEPTH)) begin
            unique case (ctrl_q.bank)
                BANK_TIME: rd_mux = digit[host_addr];
                BANK_CFG:  rd_mux = cfg_rd;
                BANK_SCRA: rd_mux = scr_rd[0 +: NIB_W];
                BANK_SCRB: rd_mux = scr_rd[NIB_W +: NIB_W];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= '0;
        else if (host_rd) host_rdata <= rd_mux;
    end

    assign timer_en = ctrl_q.count_en;
    assign alarm_en = ctrl_q.alarm_en;
endmodule

// File: rtl/rtc_rf_checker.sv
module rtc_rf_checker #(
    parameter int DEPTH   = 13,
    parameter int ALARM_W = 28
) (
    input logic               clk,
    input logic               rst,
    input logic [3:0]         host_addr,
    input logic [3:0]         host_wdata,
    input logic               host_wr,
    input logic               host_rd,
    input logic [3:0]         host_rdata,
    input logic               tcore_ld,
    input logic               tcore_inc,
    input logic               timer_en,
    input logic               div_clr,
    input logic [ALARM_W-1:0] alarm_nibs
);
    p_inc_needs_enable_r8: assert property (@(posedge clk) disable iff (rst)
        tcore_inc |-> $past(timer_en));

    p_load_from_write_r3: assert property (@(posedge clk) disable iff (rst)
        tcore_ld |-> $past(host_wr && (int'(host_addr) < DEPTH)));

    p_divclr_cause_r6: assert property (@(posedge clk) disable iff (rst)
        div_clr |-> $past(host_wr && host_addr == 4'hF && host_wdata[1]));

    p_alarm_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        $past(host_wr && host_addr == 4'hF && host_wdata[0]) |-> (alarm_nibs == '0));

    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(host_rd) |-> $stable(host_rdata));

    p_write_only_zero_r7: assert property (@(posedge clk) disable iff (rst)
        $past(host_rd && (host_addr == 4'hE || host_addr == 4'hF)) |-> (host_rdata == 4'h0));
endmodule

bind rtc_nibble_regfile rtc_rf_checker #(.DEPTH(DEPTH), .ALARM_W(ACNT*4)) chk_i (.*);

// File: tb/rtc_nibble_regfile_tb_top.sv
module rtc_nibble_regfile_tb_top;
    localparam int DEPTH = 13;
    localparam int ACNT  = 7;

    logic clk = 0, rst = 1;
    logic [3:0] host_addr = 0, host_wdata = 0;
    logic host_wr = 0, host_rd = 0, tick_1s = 0;
    logic [DEPTH*4-1:0] tcore_digits = '0;
    logic [3:0] host_rdata, tcore_ld_idx, tcore_ld_val, test_bits;
    logic tcore_ld, tcore_inc, timer_en, alarm_en, hour24, div_clr, pulse16_en, pulse1_en;
    logic [ACNT*4-1:0] alarm_nibs;
    logic [1:0] leap_phase;

    always #10 clk = ~clk;

    rtc_nibble_regfile dut_i (.*);

    // behavioural reference
    logic [3:0] m_ctrl, m_test, m_rdata, m_idx, m_val;
    logic [3:0] m_ram [2][DEPTH];
    logic [3:0] m_alarm [ACNT];
    logic m_h24, m_p16, m_p1, m_div, m_ld, m_inc, m_pend;
    logic [1:0] m_leap;
    int compared = 0, mismatched = 0, cycles = 0;
    string cur_req = "R2";
    bit started = 0;

    function automatic logic [3:0] m_lookup(input logic [3:0] a);
        if (a == 4'hD) return m_ctrl;
        if (a >= 4'hE) return 4'h0;
        case (m_ctrl[1:0])
            2'b00: return tcore_digits[a*4 +: 4];
            2'b01: begin
                if (a >= 2 && a <= 8) return m_alarm[a-2];
                if (a == 4'hA) return {3'b0, m_h24};
                if (a == 4'hB) return {2'b0, m_leap};
                return 4'h0;
            end
            2'b10: return m_ram[0][a];
            default: return m_ram[1][a];
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            m_ctrl <= 0; m_test <= 0; m_rdata <= 0; m_idx <= 0; m_val <= 0;
            m_h24 <= 0; m_p16 <= 0; m_p1 <= 0; m_div <= 0; m_ld <= 0;
            m_inc <= 0; m_pend <= 0; m_leap <= 0;
            for (int i = 0; i < DEPTH; i++) begin m_ram[0][i] <= 0; m_ram[1][i] <= 0; end
            for (int i = 0; i < ACNT; i++) m_alarm[i] <= 0;
        end else begin
            if (host_rd) m_rdata <= m_lookup(host_addr);
            m_inc  <= m_ctrl[3] && (tick_1s || m_pend);
            m_pend <= m_ctrl[3] ? (tick_1s && m_pend) : (m_pend || tick_1s);
            m_ld <= 0; m_div <= 0;
            if (host_wr) begin
                if (host_addr == 4'hD) m_ctrl <= host_wdata;
                else if (host_addr == 4'hE) m_test <= host_wdata;
                else if (host_addr == 4'hF) begin
                    if (host_wdata[0]) for (int i = 0; i < ACNT; i++) m_alarm[i] <= 0;
                    m_div <= host_wdata[1]; m_p16 <= host_wdata[2]; m_p1 <= host_wdata[3];
                end else begin
                    case (m_ctrl[1:0])
                        2'b00: begin m_ld <= 1; m_idx <= host_addr; m_val <= host_wdata; end
                        2'b01: begin
                            if (host_addr >= 2 && host_addr <= 8) m_alarm[host_addr-2] <= host_wdata;
                            if (host_addr == 4'hA) m_h24 <= host_wdata[0];
                            if (host_addr == 4'hB) m_leap <= host_wdata[1:0];
                        end
                        2'b10: m_ram[0][host_addr] <= host_wdata;
                        default: m_ram[1][host_addr] <= host_wdata;
                    endcase
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (started) begin
        logic [ACNT*4-1:0] exp_al;
        for (int i = 0; i < ACNT; i++) exp_al[i*4 +: 4] = m_alarm[i];
        chk(cur_req, "host_rdata", host_rdata, m_rdata);
        chk("R3", "tcore_ld", tcore_ld, m_ld);
        if (m_ld) begin
            chk("R3", "tcore_ld_idx", tcore_ld_idx, m_idx);
            chk("R3", "tcore_ld_val", tcore_ld_val, m_val);
        end
        chk("R8", "tcore_inc", tcore_inc, m_inc);
        chk("R8", "timer_en", timer_en, m_ctrl[3]);
        chk("R9", "alarm_en", alarm_en, m_ctrl[2]);
        chk("R5", "alarm_nibs", alarm_nibs, exp_al);
        chk("R5", "hour24", hour24, m_h24);
        chk("R5", "leap_phase", leap_phase, m_leap);
        chk("R6", "div_clr", div_clr, m_div);
        chk("R6", "pulse16_en", pulse16_en, m_p16);
        chk("R6", "pulse1_en", pulse1_en, m_p1);
        chk("R7", "test_bits", test_bits, m_test);
    end

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk); #1; host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk); #1; host_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        @(negedge clk); #1; host_addr = a; host_rd = 1;
        @(negedge clk); #1; host_rd = 0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); #1; tick_1s = 1;
        @(negedge clk); #1; tick_1s = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) tcore_digits[i*4 +: 4] = 4'(i ^ 5);
        idle(3); #1; rst = 0;
        cur_req = "R2"; rd(4'hD); idle(2);

        // R1 / R4: two scratch banks, crosswise
        cur_req = "R4";
        wr(4'hD, 4'h2);
        for (int i = 0; i < DEPTH; i++) wr(4'(i), 4'(i ^ 9));
        wr(4'hD, 4'h3);
        for (int i = 0; i < DEPTH; i++) wr(4'(i), 4'(15 - i));
        for (int i = 0; i < DEPTH; i++) rd(4'(i));
        cur_req = "R1"; rd(4'hD);
        wr(4'hD, 4'h2);
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) rd(4'(i));

        // R5: alarm and configuration bank
        cur_req = "R5";
        wr(4'hD, 4'h1);
        for (int i = 2; i <= 8; i++) wr(4'(i), 4'(i + 3));
        wr(4'h0, 4'h7); wr(4'h1, 4'h7); wr(4'h9, 4'h7); wr(4'hC, 4'h7);
        wr(4'hA, 4'hF); wr(4'hB, 4'h6);
        for (int i = 0; i < DEPTH; i++) rd(4'(i));

        // R6: command nibble
        cur_req = "R6";
        wr(4'hF, 4'h1);
        for (int i = 0; i < DEPTH; i++) rd(4'(i));
        wr(4'hF, 4'hE); rd(4'hF);
        wr(4'hF, 4'h0);

        // R7: test nibble
        cur_req = "R7";
        wr(4'hE, 4'h5); rd(4'hE);

        // R9: alarm enable
        cur_req = "R9";
        wr(4'hD, 4'h5); rd(4'hD);

        // R3: time digits
        cur_req = "R3";
        wr(4'hD, 4'h0);
        wr(4'h3, 4'h6); wr(4'hC, 4'h9);
        for (int i = 0; i < DEPTH; i++) rd(4'(i));
        for (int i = 0; i < DEPTH; i++) tcore_digits[i*4 +: 4] = 4'(3 * i + 1);
        for (int i = 0; i < DEPTH; i++) rd(4'(i));

        // R8: tick gating and single pending carry
        cur_req = "R8";
        wr(4'hD, 4'h8); tick(); idle(2); tick(); tick();
        wr(4'hD, 4'h0); tick(); idle(1); tick(); tick(); idle(3);
        wr(4'hD, 4'h8); idle(4);
        wr(4'hD, 4'h0); tick(); idle(2);
        @(negedge clk); #1; host_addr = 4'hD; host_wdata = 4'h8; host_wr = 1; tick_1s = 1;
        @(negedge clk); #1; host_wr = 0; tick_1s = 0;
        idle(4);

        finish_run();
    end
endmodule